// File: doc/BRIEF.md
# Split-Half Voltage Code Transmitter

This block delivers a 6-bit voltage identification code to an external core-voltage regulator over four output pins. Three pins carry data. The fourth pin is a phase select that tells the regulator which half of the code is on the data pins. The block runs from the system clock. A single-cycle start pulse captures the code. The block then presents the low half for a fixed hold time, then the high half for the same hold time. After that it waits a settling interval so the regulator can move the rail away from its 1.1 V default.

Once settling ends, a ready flag tells the rest of the system that application code may run. The pins keep showing the high half until the next request. The hold time and the settle time are parameters counted in clock cycles. An elaboration-time check rejects a hold count that is shorter than 70 µs at the stated clock rate, or longer than 172020 clock periods.

Top module: `vid_split_tx`

## Requirements
- R1: While the synchronous reset is applied, and in the first cycle after it, all four pins, `busy` and `ready` are low.
- R2: A start pulse sampled while idle captures `vidCode`. From the next cycle, `vidPins[3]` (select) is 0, `vidPins[2:0]` equals `vidCode[2:0]`, `busy` is 1 and `ready` is 0.
- R3: The low half is held for exactly HOLD_CYCLES cycles. In the cycle after that, select becomes 1 and `vidPins[2:0]` becomes `vidCode[5:3]` at the same clock edge.
- R4: The high half is held for exactly HOLD_CYCLES cycles. The order is always low half first, then high half.
- R5: After the high half, `busy` stays 1 for SETTLE_CYCLES further cycles. Then `ready` rises and `busy` falls in the same cycle. `ready` is never 1 while `busy` is 1.
- R6: A start pulse, or a change of `vidCode`, while `busy` is 1 has no effect on the pins or on the timing of the transfer in progress.
- R7: After completion, select stays 1, the data pins keep the high half, and `ready` stays 1 until the next start pulse.
- R8: A start pulse while idle after a completed transfer begins a new transfer, and `ready` falls.
- R9: The data pins and the select pin change only at a capture edge or at the half-switch edge. Both are driven from registers, so the data are valid within one clock of any select transition.
- R10: Elaboration fails if HOLD_CYCLES is below ceil(CLK_KHZ·0.07) or above 172020.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to send `vidCode` |
| vidCode | input | 6 | Voltage identification code to send |
| vidPins | output | 4 | [3] half select (0 = low half, 1 = high half), [2:0] data |
| busy | output | 1 | Transfer or settling in progress |
| ready | output | 1 | Selected voltage is settled; application code may run |

## Verification
The hardest situations to reach from the ports are a second request arriving in the middle of a transfer and a reset that cuts a transfer short. A correct design hides the first of these entirely. The bench sweeps all 64 codes. In every run it drives an intruding start with the inverted code during the low phase, and it checks every cycle of the run against a timeline computed from the hold and settle counts. A separate run asserts reset partway through the low half and confirms that the pins clear and that a fresh transfer then starts cleanly.

// File: rtl/vid_split_pkg.sv
package vid_split_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOW    = 2'd1,
    ST_HIGH   = 2'd2,
    ST_SETTLE = 2'd3
  } vidState_e;

  typedef struct packed {
    logic latchLow;   // capture code, present low half
    logic driveHigh;  // present high half
    logic setReady;   // settling done
  } vidStrobe_t;
endpackage

// File: rtl/vid_split_ctrl.sv
module vid_split_ctrl
  import vid_split_pkg::*;
#(
  parameter int HOLD_CYCLES   = 4000,
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output vidStrobe_t strb,
  output logic       busy
);
  localparam int MAX_CNT = (HOLD_CYCLES > SETTLE_CYCLES) ? HOLD_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

  vidState_e       state;
  logic [CNT_W-1:0] cnt;
  logic            holdDone;
  logic            settleDone;

  assign holdDone   = (cnt == HOLD_LAST);
  assign settleDone = (cnt == SETTLE_LAST);

  always_comb begin
    strb.latchLow  = (state == ST_IDLE) && start;
    strb.driveHigh = (state == ST_LOW) && holdDone;
    strb.setReady  = (state == ST_SETTLE) && settleDone;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_LOW;
        end
        ST_LOW: begin
          if (holdDone) begin
            state <= ST_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (holdDone) begin
            state <= ST_SETTLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (settleDone) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R4: high phase is entered only from the low phase
  p_high_after_low_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIGH) |-> ($past(state) == ST_HIGH || $past(state) == ST_LOW));

  // R5: settling follows the high phase
  p_settle_after_high_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE) |-> ($past(state) == ST_SETTLE || $past(state) == ST_HIGH));

  // R3: hold counter stays inside the hold window
  p_hold_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW || state == ST_HIGH) |-> (cnt <= HOLD_LAST));

  // R6: a start during the low phase does not restart the count
  p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_LOW && state == ST_LOW && !$past(rst)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/vid_split_dp.sv
module vid_split_dp
  import vid_split_pkg::*;
#(
  parameter int HALF_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  vidStrobe_t          strb,
  input  logic [2*HALF_W-1:0] code,
  output logic [HALF_W-1:0]   dataPins,
  output logic                selPin,
  output logic                ready
);
  logic [HALF_W-1:0] hiHalf;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiHalf   <= '0;
      dataPins <= '0;
      selPin   <= 1'b0;
      ready    <= 1'b0;
    end else begin
      if (strb.latchLow) begin
        hiHalf   <= code[2*HALF_W-1:HALF_W];
        dataPins <= code[HALF_W-1:0];
        selPin   <= 1'b0;
        ready    <= 1'b0;
      end else if (strb.driveHigh) begin
        dataPins <= hiHalf;
        selPin   <= 1'b1;
      end
      if (strb.setReady) ready <= 1'b1;
    end
  end

  // R9: pins move only on a capture or half-switch strobe
  p_pins_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strb.latchLow) && !$past(strb.driveHigh))
      |-> ($stable(dataPins) && $stable(selPin)));

  // R3: select rises only on the half-switch strobe
  p_sel_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(selPin) |-> $past(strb.driveHigh));
endmodule

// File: rtl/vid_split_tx.sv
module vid_split_tx
  import vid_split_pkg::*;
#(
  parameter int HALF_W        = 3,
  parameter int CLK_KHZ       = 50000,
  parameter int HOLD_CYCLES   = 4000,
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2*HALF_W-1:0] vidCode,
  output logic [HALF_W:0]     vidPins,
  output logic                busy,
  output logic                ready
);
  localparam int HOLD_MIN = (CLK_KHZ * 7 + 99) / 100;
  localparam int HOLD_MAX = 172020;

  // R10: hold window check at elaboration
  if (HOLD_CYCLES < HOLD_MIN || HOLD_CYCLES > HOLD_MAX) begin : g_holdBad
    $error("vid_split_tx: HOLD_CYCLES outside permitted window");
  end

  vidStrobe_t        strb;
  logic [HALF_W-1:0] dataPins;
  logic              selPin;

  vid_split_ctrl #(
    .HOLD_CYCLES  (HOLD_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .strb (strb),
    .busy (busy)
  );

  vid_split_dp #(
    .HALF_W(HALF_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .code    (vidCode),
    .dataPins(dataPins),
    .selPin  (selPin),
    .ready   (ready)
  );

  assign vidPins = {selPin, dataPins};

  // R5: ready and busy never overlap
  p_ready_idle_r5: assert property (@(posedge clk) disable iff (rst)
    ready |-> !busy);

  // R7: once settled, pins and ready hold until a start arrives
  p_settled_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> (ready && $stable(vidPins)));
endmodule

// File: tb/vid_split_tx_tb.sv
module vid_split_tx_tb;
  localparam int HOLD   = 8;
  localparam int SETTLE = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [5:0] vidCode = '0;
  logic [3:0] vidPins;
  logic       busy;
  logic       ready;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  vid_split_tx #(
    .HALF_W       (3),
    .CLK_KHZ      (100),
    .HOLD_CYCLES  (HOLD),
    .SETTLE_CYCLES(SETTLE)
  ) u_dut (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .vidCode(vidCode),
    .vidPins(vidPins),
    .busy   (busy),
    .ready  (ready)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [3:0] expPins,
                       input logic expBusy, input logic expReady);
    checks++;
    if (vidPins !== expPins || busy !== expBusy || ready !== expReady) begin
      fails++;
      $display("FAIL %s: pins=%b busy=%b ready=%b expected pins=%b busy=%b ready=%b",
               req, vidPins, busy, ready, expPins, expBusy, expReady);
    end
  endtask

  // j counts clock edges since the capture edge
  task automatic runVid(input logic [5:0] c, input bit intrude);
    vidCode = c;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < 2*HOLD + SETTLE + 4; j++) begin
      if (j < HOLD)
        check(j == 0 ? "R2" : (intrude ? "R6" : "R3"), {1'b0, c[2:0]}, 1'b1, 1'b0);
      else if (j < 2*HOLD)
        check(j == HOLD ? "R3" : "R4", {1'b1, c[5:3]}, 1'b1, 1'b0);
      else if (j < 2*HOLD + SETTLE)
        check("R5", {1'b1, c[5:3]}, 1'b1, 1'b0);
      else
        check(j == 2*HOLD + SETTLE ? "R5" : "R7", {1'b1, c[5:3]}, 1'b0, 1'b1);
      if (intrude && j == 3) begin
        start   = 1'b1;
        vidCode = ~c;
      end else begin
        start   = 1'b0;
        vidCode = (j > 2*HOLD + SETTLE) ? c + 6'd1 : vidCode;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1", 4'b0000, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    check("R1", 4'b0000, 1'b0, 1'b0);
    @(negedge clk);
    check("R1", 4'b0000, 1'b0, 1'b0);

    // sweep of every code, each with a mid-transfer intruding start
    for (int c = 0; c < 64; c++) runVid(6'(c), 1'b1);

    // plain back-to-back runs: restart after completion (R8)
    runVid(6'b101_010, 1'b0);
    runVid(6'b010_101, 1'b0);

    // reset partway through the low half
    vidCode = 6'b111_111;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 4'b0000, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 4'b0000, 1'b0, 1'b0);
    runVid(6'b001_110, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule